// File: doc/BRIEF.md
# Configuration Start-up Sequencer

This block takes a device from the end of configuration loading into user operation. A length counter outside the block reports with a one-cycle pulse that the full bitstream has arrived. That pulse drops a single token into a five-stage shift chain. The token moves one stage per start-up clock edge. As it passes the stages it releases the global output-disable (3-state) net, raises the DONE flag and releases the global set/reset net, in that order. A sticky "finished" flag then marks that start-up is over. Later logic uses this flag to enable readback, boundary scan and oscillator control.

A static option picks the start-up clock, either the configuration clock or a clock supplied by the user's logic. A second option makes each release wait until the external DONE input is high. The user's design may also drive its own set/reset and 3-state control nets. Each of these nets has its own enable and polarity-invert options, and the gated result is ORed into the matching global output. A memory-clear input holds the whole sequencer in its initial state.

Top module: `startup_seq`

## Requirements
- R1: While memClear is high, and after it falls until a start pulse is accepted, gtsOut and gsrOut are high (when the user overrides are inactive), and doneOut and finished are low.
- R2: A high lengthFull while the sequencer is idle puts the token in stage 0 on that start-up clock edge. The token then advances one stage per edge, and only one stage holds it at any time.
- R3: The internal 3-state hold is released when the token enters stage 2, and it stays released until memClear.
- R4: doneOut goes high when the token enters stage 3 and stays high until memClear.
- R5: The internal set/reset hold is released when the token enters stage 4. finished goes high on the following edge and stays high until memClear.
- R6: With clkSel = 0 the sequencer steps on cfgClk, and with clkSel = 1 it steps on userClk. clkSel is changed only while memClear is high.
- R7: gsrOut is high when the internal hold is active or when gsrEn = 1 and (userGsr XOR gsrInv) = 1.
- R8: gtsOut is high when the internal hold is active or when gtsEn = 1 and (userGts XOR gtsInv) = 1.
- R9: With waitDone = 1 and doneIn low, a token in stage 1, 2 or 3 does not move. It moves on the first edge where doneIn is high.
- R10: waitDone, gsrEn, gsrInv, gtsEn and gtsInv are captured on every edge while the sequencer is idle. Changes after a start has been accepted have no effect until the next memClear.
- R11: lengthFull has no effect while a token is in the chain or after finished is high.
- R12: memClear in the middle of a sequence returns all outputs and the chain to the initial state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgClk | input | 1 | Configuration clock |
| userClk | input | 1 | Clock supplied by user logic |
| clkSel | input | 1 | Start-up clock select (0 = cfgClk, 1 = userClk) |
| memClear | input | 1 | Asynchronous hold in the initial state, active high |
| lengthFull | input | 1 | Pulse from the length counter when the full count is reached |
| doneIn | input | 1 | External DONE level |
| waitDone | input | 1 | Option: hold releases until doneIn is high |
| userGsr | input | 1 | User set/reset control net |
| gsrEn | input | 1 | Option: enable userGsr |
| gsrInv | input | 1 | Option: invert userGsr |
| userGts | input | 1 | User 3-state control net |
| gtsEn | input | 1 | Option: enable userGts |
| gtsInv | input | 1 | Option: invert userGts |
| gsrOut | output | 1 | Global set/reset, active high |
| gtsOut | output | 1 | Global 3-state of all I/O, active high |
| doneOut | output | 1 | DONE flag |
| finished | output | 1 | Start-up complete |

## Verification
The assertions check the following on every start-up clock edge:
- the chain holds at most one token;
- a start enters stage 0;
- a token is never injected while the chain is busy or finished;
- the stall under wait-for-DONE;
- gtsOut and gsrOut stay high before their release stages;
- DONE and finished are sticky, and finished implies DONE.

Some behaviour shows only in the bench's scenarios, where a behavioural model is compared with the outputs on every edge. This covers the exact release cycles, the choice of clock, the freezing of the options once a start is accepted, and the ORing of the user overrides with each polarity.

// File: rtl/startup_pkg.sv
package startup_pkg;
  // Static option bits, captured while idle.
  typedef struct packed {
    logic waitDone;
    logic gsrEn;
    logic gsrInv;
    logic gtsEn;
    logic gtsInv;
  } opt_t;

  // Strobes from the control chain to the datapath.
  typedef struct packed {
    logic capture;  // sequencer idle: sample options
    logic gtsGo;    // token in the 3-state release stage
    logic doneGo;   // token in the DONE stage
    logic gsrGo;    // token in the set/reset release stage
    logic finish;   // token in the last stage
  } strobe_t;
endpackage

// File: rtl/startup_ctrl.sv
module startup_ctrl
  import startup_pkg::*;
#(
  parameter int NUM_STAGES = 5,
  parameter int GTS_STAGE  = 2,
  parameter int DONE_STAGE = 3,
  parameter int GSR_STAGE  = 4
) (
  input  logic                  clk,
  input  logic                  memClear,
  input  logic                  lengthFull,
  input  logic                  doneIn,
  input  logic                  waitDone,
  input  logic                  finished,
  output strobe_t               strb,
  output logic [NUM_STAGES-1:0] stageQ
);
  localparam int LAST = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] stageNext;
  logic idle;
  logic startNow;
  logic stallNow;

  assign idle     = (stageQ == '0) && !finished;
  assign startNow = idle && lengthFull;
  // Stall only while the token sits between the first and last stage.
  assign stallNow = waitDone && !doneIn && (|stageQ[LAST-1:1]);

  assign stageNext[0] = startNow;

  for (genvar i = 1; i < NUM_STAGES; i++) begin : gChain
    assign stageNext[i] = stallNow ? stageQ[i] : stageQ[i-1];
  end

  always_ff @(posedge clk or posedge memClear) begin
    if (memClear) stageQ <= '0;
    else          stageQ <= stageNext;
  end

  always_comb begin
    strb.capture = idle;
    strb.gtsGo   = stageQ[GTS_STAGE];
    strb.doneGo  = stageQ[DONE_STAGE];
    strb.gsrGo   = stageQ[GSR_STAGE];
    strb.finish  = stageQ[LAST];
  end
endmodule

// File: rtl/startup_dp.sv
module startup_dp
  import startup_pkg::*;
(
  input  logic    clk,
  input  logic    memClear,
  input  strobe_t strb,
  input  opt_t    optIn,
  input  logic    userGsr,
  input  logic    userGts,
  output opt_t    optQ,
  output logic    gsrOut,
  output logic    gtsOut,
  output logic    doneOut,
  output logic    finished
);
  logic gtsRel;
  logic doneRel;
  logic finReg;
  logic sysGtsRel;
  logic sysGsrRel;
  logic userGsrHit;
  logic userGtsHit;

  always_ff @(posedge clk or posedge memClear) begin
    if (memClear) begin
      optQ    <= '0;
      gtsRel  <= 1'b0;
      doneRel <= 1'b0;
      finReg  <= 1'b0;
    end else begin
      if (strb.capture) optQ <= optIn;
      gtsRel  <= gtsRel  | strb.gtsGo;
      doneRel <= doneRel | strb.doneGo;
      finReg  <= finReg  | strb.finish;
    end
  end

  assign sysGtsRel  = gtsRel | strb.gtsGo;
  assign sysGsrRel  = finReg | strb.gsrGo;
  assign userGsrHit = optQ.gsrEn & (userGsr ^ optQ.gsrInv);
  assign userGtsHit = optQ.gtsEn & (userGts ^ optQ.gtsInv);

  assign gsrOut   = ~sysGsrRel | userGsrHit;
  assign gtsOut   = ~sysGtsRel | userGtsHit;
  assign doneOut  = doneRel | strb.doneGo;
  assign finished = finReg;
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_pkg::*;
#(
  parameter int NUM_STAGES = 5,
  parameter int GTS_STAGE  = 2,
  parameter int DONE_STAGE = 3,
  parameter int GSR_STAGE  = 4
) (
  input  logic cfgClk,
  input  logic userClk,
  input  logic clkSel,
  input  logic memClear,
  input  logic lengthFull,
  input  logic doneIn,
  input  logic waitDone,
  input  logic userGsr,
  input  logic gsrEn,
  input  logic gsrInv,
  input  logic userGts,
  input  logic gtsEn,
  input  logic gtsInv,
  output logic gsrOut,
  output logic gtsOut,
  output logic doneOut,
  output logic finished
);
  logic                  startClk;
  strobe_t               strb;
  opt_t                  optIn;
  opt_t                  optQ;
  logic [NUM_STAGES-1:0] stageQ;
  logic                  waitOpt;

  // Static option: changed only under memClear.
  assign startClk = clkSel ? userClk : cfgClk;
  assign optIn    = '{waitDone: waitDone, gsrEn: gsrEn, gsrInv: gsrInv,
                      gtsEn: gtsEn, gtsInv: gtsInv};
  assign waitOpt  = optQ.waitDone;

  startup_ctrl #(
    .NUM_STAGES(NUM_STAGES), .GTS_STAGE(GTS_STAGE),
    .DONE_STAGE(DONE_STAGE), .GSR_STAGE(GSR_STAGE)
  ) uCtrl (
    .clk(startClk), .memClear(memClear), .lengthFull(lengthFull),
    .doneIn(doneIn), .waitDone(waitOpt), .finished(finished),
    .strb(strb), .stageQ(stageQ)
  );

  startup_dp uDp (
    .clk(startClk), .memClear(memClear), .strb(strb), .optIn(optIn),
    .userGsr(userGsr), .userGts(userGts), .optQ(optQ),
    .gsrOut(gsrOut), .gtsOut(gtsOut), .doneOut(doneOut), .finished(finished)
  );
endmodule

// File: rtl/startup_chk.sv
module startup_chk #(
  parameter int NUM_STAGES = 5,
  parameter int GTS_STAGE  = 2,
  parameter int GSR_STAGE  = 4
) (
  input logic                  clk,
  input logic                  memClear,
  input logic                  lengthFull,
  input logic                  doneIn,
  input logic                  waitOpt,
  input logic [NUM_STAGES-1:0] stageQ,
  input logic                  gsrOut,
  input logic                  gtsOut,
  input logic                  doneOut,
  input logic                  finished
);
  AST_ONE_TOKEN: assert property (@(posedge clk) disable iff (memClear)
    $onehot0(stageQ));  // R2
  AST_START_TOKEN: assert property (@(posedge clk) disable iff (memClear)
    (stageQ == '0 && !finished && lengthFull) |=> (stageQ == 1));  // R2
  AST_NO_INJECT: assert property (@(posedge clk) disable iff (memClear)
    (stageQ != '0 || finished) |=> !stageQ[0]);  // R11
  AST_GTS_HELD: assert property (@(posedge clk) disable iff (memClear)
    (|stageQ[GTS_STAGE-1:0]) |-> gtsOut);  // R3
  AST_GSR_HELD: assert property (@(posedge clk) disable iff (memClear)
    (|stageQ[GSR_STAGE-1:0]) |-> gsrOut);  // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (memClear)
    doneOut |=> doneOut);  // R4
  AST_FIN_STICKY: assert property (@(posedge clk) disable iff (memClear)
    finished |=> finished);  // R5
  AST_FIN_DONE: assert property (@(posedge clk) disable iff (memClear)
    finished |-> doneOut);  // R4
  AST_WAIT_STALL: assert property (@(posedge clk) disable iff (memClear)
    ((|stageQ[NUM_STAGES-2:1]) && waitOpt && !doneIn) |=> $stable(stageQ));  // R9
endmodule

bind startup_seq startup_chk #(
  .NUM_STAGES(NUM_STAGES), .GTS_STAGE(GTS_STAGE), .GSR_STAGE(GSR_STAGE)
) uChk (
  .clk(startClk), .memClear(memClear), .lengthFull(lengthFull),
  .doneIn(doneIn), .waitOpt(waitOpt), .stageQ(stageQ),
  .gsrOut(gsrOut), .gtsOut(gtsOut), .doneOut(doneOut), .finished(finished)
);

// File: tb/sim_startup_seq.sv
`timescale 1ns/1ps
module sim_startup_seq;
  logic cfgClk = 1'b0;
  logic userClk = 1'b0;
  logic clkSel = 1'b0, memClear = 1'b1, lengthFull = 1'b0, doneIn = 1'b0;
  logic waitDone = 1'b0, userGsr = 1'b0, gsrEn = 1'b0, gsrInv = 1'b0;
  logic userGts = 1'b0, gtsEn = 1'b0, gtsInv = 1'b0;
  logic gsrOut, gtsOut, doneOut, finished;

  int vectors = 0;
  int fails = 0;
  string curReq = "R1";

  // Behavioural model: stage -1 idle, 0..4 token position, 5 finished.
  int   mStage = -1;
  logic mWait = 1'b0, mGsrEn = 1'b0, mGsrInv = 1'b0, mGtsEn = 1'b0, mGtsInv = 1'b0;

  always #10 cfgClk = ~cfgClk;   // 50 MHz
  always #15 userClk = ~userClk;

  startup_seq u0 (
    .cfgClk(cfgClk), .userClk(userClk), .clkSel(clkSel), .memClear(memClear),
    .lengthFull(lengthFull), .doneIn(doneIn), .waitDone(waitDone),
    .userGsr(userGsr), .gsrEn(gsrEn), .gsrInv(gsrInv),
    .userGts(userGts), .gtsEn(gtsEn), .gtsInv(gtsInv),
    .gsrOut(gsrOut), .gtsOut(gtsOut), .doneOut(doneOut), .finished(finished)
  );

  task automatic modelClear();
    mStage = -1;
    mWait = 0; mGsrEn = 0; mGsrInv = 0; mGtsEn = 0; mGtsInv = 0;
  endtask

  task automatic modelStep();
    int nxt;
    if (memClear) begin
      modelClear();
    end else begin
      nxt = mStage;
      if (mStage == -1) begin
        if (lengthFull) nxt = 0;
        mWait = waitDone; mGsrEn = gsrEn; mGsrInv = gsrInv;
        mGtsEn = gtsEn; mGtsInv = gtsInv;
      end else if (mStage >= 1 && mStage <= 3 && mWait && !doneIn) begin
        nxt = mStage;
      end else if (mStage < 5) begin
        nxt = mStage + 1;
      end
      mStage = nxt;
    end
  endtask

  always @(posedge cfgClk)  if (!clkSel) modelStep();
  always @(posedge userClk) if (clkSel)  modelStep();

  task automatic checkBit(string name, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (stage %0d)", curReq, name, act, exp, mStage);
    end
  endtask

  task automatic compareAll();
    logic expGts, expGsr;
    expGts = (mStage < 2) | (mGtsEn & (userGts ^ mGtsInv));
    expGsr = (mStage < 4) | (mGsrEn & (userGsr ^ mGsrInv));
    checkBit("gtsOut", gtsOut, expGts);
    checkBit("gsrOut", gsrOut, expGsr);
    checkBit("doneOut", doneOut, mStage >= 3);
    checkBit("finished", finished, mStage == 5);
  endtask

  task automatic tick();
    if (clkSel) @(negedge userClk);
    else        @(negedge cfgClk);
    compareAll();
  endtask

  task automatic doReset(logic sel);
    memClear = 1'b1;
    modelClear();
    clkSel = sel;
    lengthFull = 1'b0;
    tick(); tick();
    memClear = 1'b0;
    tick(); tick();
  endtask

  task automatic startPulse();
    lengthFull = 1'b1;
    tick();
    lengthFull = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge cfgClk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1: initial state under and after memClear
    curReq = "R1";
    doReset(1'b0);

    // R2 R3 R4 R5: plain sequence on cfgClk
    curReq = "R2"; startPulse(); tick();
    curReq = "R3"; tick();
    curReq = "R4"; tick();
    curReq = "R5"; tick(); tick(); tick();
    // R11: start pulse after finished is ignored
    curReq = "R11"; startPulse(); tick(); tick();

    // R7 R8 R10: user overrides, options frozen after start
    curReq = "R7";
    gsrEn = 1; gsrInv = 0; gtsEn = 1; gtsInv = 1; userGsr = 0; userGts = 1;
    doReset(1'b0);
    startPulse();
    curReq = "R10"; gtsInv = 0; gsrInv = 1; tick(); tick();
    curReq = "R8"; userGts = 0; tick(); userGts = 1; tick();
    curReq = "R7"; userGsr = 1; tick(); userGsr = 0; tick(); tick(); tick();
    gsrInv = 0; gtsInv = 1;

    // R6: user clock selected
    curReq = "R6";
    gsrEn = 0; gtsEn = 0;
    doReset(1'b1);
    startPulse();
    repeat (7) tick();

    // R9 R11: wait for external DONE, start pulses ignored while busy
    curReq = "R9";
    waitDone = 1; doneIn = 0;
    doReset(1'b0);
    startPulse(); tick();
    repeat (4) tick();
    curReq = "R11"; startPulse(); tick();
    curReq = "R9"; doneIn = 1; tick(); doneIn = 0; repeat (3) tick();
    doneIn = 1; repeat (5) tick();
    waitDone = 0; doneIn = 0;

    // R12: memClear mid-sequence
    curReq = "R12";
    doReset(1'b0);
    startPulse(); tick(); tick(); tick();
    memClear = 1'b1; modelClear();
    #1;
    checkBit("gtsOut", gtsOut, 1'b1);
    checkBit("doneOut", doneOut, 1'b0);
    checkBit("gsrOut", gsrOut, 1'b1);
    tick();
    memClear = 1'b0;
    tick(); tick();
    startPulse();
    repeat (7) tick();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule